// File: doc/BRIEF.md
# Four-Register Multi-Cycle Microprocessor Core

This block is a compact multi-cycle processor core with four general-purpose data registers and a program counter. It talks to one synchronous memory through a single address, write-data, write-enable and read-data port. A condition input steers the conditional branch. Instructions are one byte wide. Memory-access and branch instructions are followed by a second byte that holds an absolute address.

Each instruction runs as a short sequence of states. The sequence fetches the opcode byte, decodes it, fetches the address byte when the opcode needs one, and then executes. A memory load adds one more cycle for the data to return. The core suits small control tasks where area matters more than throughput.

Top module: `ucpu_core`

## Requirements
- R1: A synchronous active-high reset `rst` sets the program counter and all four registers to zero. The first fetch after reset presents address 0, and `mem_we` stays low while reset is held.
- R2: An instruction byte is laid out as bits [7:6] major opcode, bit [5] sub-code, bits [4:3] destination register select, bits [2:1] source register select, and bit [0] unused. The value of bit [0] has no effect.
- R3: Major opcode 0 with sub-code 0 is a load. It writes the memory byte at the address in the following word into the destination register and advances the program counter by 2.
- R4: Major opcode 0 with sub-code 1 is a store. It writes the source register to the address in the following word, holds `mem_we` high for exactly one cycle, and advances the program counter by 2.
- R5: Major opcode 1 copies the source register into the destination register. With sub-code 0 the value is copied unchanged; with sub-code 1 its bitwise inverse is copied. The program counter advances by 1.
- R6: Major opcode 2 with sub-code 0 adds the source register to the destination register; with sub-code 1 it subtracts the source from the destination. Results wrap modulo 2^8 and the program counter advances by 1.
- R7: Only the register selected by the destination field is written, and only by load, copy/invert and add/subtract. No other register changes, and a store or branch changes no register.
- R8: Major opcode 3 with sub-code 0 loads the program counter with the address in the following word.
- R9: Major opcode 3 with sub-code 1 loads the program counter with the following word when `cond_in` is 1 at execution. Otherwise the program counter advances by 2.
- R10: Memory reads return data on `mem_rdata` one cycle after the address is presented. The core only drives `mem_we` during the execute cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address for fetch, read or write |
| mem_wdata | output | 8 | Store data, taken from the source register |
| mem_we | output | 1 | Memory write strobe, one cycle per store |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| cond_in | input | 1 | Condition sampled by the conditional branch |

## Verification
Register contents are hidden, so a wrong register value or a write to the wrong register only becomes visible at the next store of that register. It shows on `mem_wdata` during the single `mem_we` cycle. The test program therefore stores every register it changes immediately afterwards, so a wrong value shows up within about six cycles. A wrong program counter after a branch or a two-word instruction changes the fetch stream. It shows up as a store to an unexpected address, a missing store, or an address outside the final self-loop.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;

   localparam int INSTR_W = 8;

   typedef enum logic [1:0] {
      OP_MEM   = 2'd0,
      OP_MOVE  = 2'd1,
      OP_ARITH = 2'd2,
      OP_JUMP  = 2'd3
   } ucpu_op_e;

   typedef struct packed {
      ucpu_op_e   op;
      logic       sub;
      logic [1:0] dst;
      logic [1:0] src;
      logic       spare;
   } ucpu_instr_t;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_ADDR   = 3'd2,
      ST_EXEC   = 3'd3,
      ST_LOAD   = 3'd4
   } ucpu_state_e;

endpackage

// File: rtl/ucpu_regfile.sv
module ucpu_regfile #(
   parameter int DATA_W = 8,
   parameter int NREGS  = 4,
   localparam int SEL_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_a_sel,
   input  logic [SEL_W-1:0]  rd_b_sel,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);

   initial begin
      assert (NREGS >= 2 && (1 << SEL_W) == NREGS)
         else $error("ucpu_regfile: NREGS must be a power of two");
   end

   logic [NREGS-1:0][DATA_W-1:0] regs_q;

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(i));

      always_ff @(posedge clk) begin
         if (rst)      regs_q[i] <= '0;
         else if (hit) regs_q[i] <= wr_data;
      end

      // R7: a register outside the write select keeps its value
      a_r7_unselected_hold: assert property (@(posedge clk) disable iff (rst)
         !(wr_en && wr_sel == SEL_W'(i)) |=> $stable(regs_q[i]));
   end

   assign rd_a = regs_q[rd_a_sel];
   assign rd_b = regs_q[rd_b_sel];

endmodule

// File: rtl/ucpu_alu.sv
module ucpu_alu
   import ucpu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  ucpu_op_e          op,
   input  logic              sub,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   logic [DATA_W-1:0] arith_y;
   logic [DATA_W-1:0] move_y;

   if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] b_eff;
      assign b_eff   = sub ? ~b : b;
      assign arith_y = a + b_eff + DATA_W'(sub);
   end else begin : g_split
      logic [DATA_W-1:0] sum_y;
      logic [DATA_W-1:0] dif_y;
      assign sum_y   = a + b;
      assign dif_y   = a - b;
      assign arith_y = sub ? dif_y : sum_y;
   end

   assign move_y = sub ? ~b : b;

   always_comb begin
      case (op)
         OP_ARITH: y = arith_y;
         default:  y = move_y;
      endcase
   end

   // R6: a wrapped difference plus the subtrahend gives back the minuend
   always_comb begin
      if (op == OP_ARITH && sub) begin
         a_r6_sub_inverse: assert (DATA_W'(y + b) == a);
      end
   end

endmodule

// File: rtl/ucpu_ctrl.sv
module ucpu_ctrl
   import ucpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              cond_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output ucpu_op_e          op,
   output logic              sub,
   output logic [1:0]        dst_sel,
   output logic [1:0]        src_sel,
   output logic              rf_we,
   output logic              use_load
);

   ucpu_state_e       state;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] areg;
   ucpu_instr_t       ir;
   ucpu_instr_t       dec;
   logic [ADDR_W-1:0] pc_one;
   logic [ADDR_W-1:0] pc_two;
   logic              unused_spare;

   assign dec          = ucpu_instr_t'(mem_rdata[INSTR_W-1:0]);
   assign pc_one       = pc + ADDR_W'(1);
   assign pc_two       = pc + ADDR_W'(2);
   assign unused_spare = ir.spare;

   assign op      = ir.op;
   assign sub     = ir.sub;
   assign dst_sel = ir.dst;
   assign src_sel = ir.src;

   always_comb begin
      mem_addr = pc;
      mem_we   = 1'b0;
      rf_we    = 1'b0;
      use_load = 1'b0;
      case (state)
         ST_DECODE: mem_addr = pc_one;
         ST_ADDR:   mem_addr = pc_one;
         ST_EXEC: begin
            if (ir.op == OP_MEM) begin
               mem_addr = areg;
               mem_we   = ir.sub;
            end else if (ir.op != OP_JUMP) begin
               rf_we = 1'b1;
            end
         end
         ST_LOAD: begin
            mem_addr = areg;
            rf_we    = 1'b1;
            use_load = 1'b1;
         end
         default: mem_addr = pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         pc    <= '0;
         areg  <= '0;
         ir    <= '0;
      end else begin
         case (state)
            ST_FETCH: state <= ST_DECODE;
            ST_DECODE: begin
               ir    <= dec;
               state <= (dec.op == OP_MEM || dec.op == OP_JUMP) ? ST_ADDR : ST_EXEC;
            end
            ST_ADDR: begin
               areg  <= mem_rdata[ADDR_W-1:0];
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               case (ir.op)
                  OP_MEM: begin
                     if (ir.sub) begin
                        pc    <= pc_two;
                        state <= ST_FETCH;
                     end else begin
                        state <= ST_LOAD;
                     end
                  end
                  OP_JUMP: begin
                     pc    <= (!ir.sub || cond_in) ? areg : pc_two;
                     state <= ST_FETCH;
                  end
                  default: begin
                     pc    <= pc_one;
                     state <= ST_FETCH;
                  end
               endcase
            end
            ST_LOAD: begin
               pc    <= pc_two;
               state <= ST_FETCH;
            end
            default: state <= ST_FETCH;
         endcase
      end
   end

   // R1: reset leaves the core fetching from address zero with no write
   a_r1_reset_start: assert property (@(posedge clk)
      rst |=> (pc == '0 && mem_addr == '0 && !mem_we));

   // R4: a store strobe lasts a single cycle
   a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   // R10: fetch moves to decode and leaves the program counter alone
   a_r10_fetch_hold: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (state == ST_DECODE && $stable(pc)));

   // R3: finishing a load moves past both words
   a_r3_load_step: assert property (@(posedge clk) disable iff (rst)
      (state == ST_LOAD) |=> (pc == ADDR_W'($past(pc) + 2)));

   // R9: an untaken conditional branch skips its address word
   a_r9_cond_fallthrough: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && ir.op == OP_JUMP && ir.sub && !cond_in)
      |=> (pc == ADDR_W'($past(pc) + 2)));

endmodule

// File: rtl/ucpu_core.sv
module ucpu_core
   import ucpu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 8,
   parameter int NREGS        = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              cond_in
);

   initial begin
      assert (DATA_W >= INSTR_W)
         else $error("ucpu_core: data word must hold an instruction");
      assert (ADDR_W <= DATA_W)
         else $error("ucpu_core: address must fit in one data word");
      assert (NREGS == 4)
         else $error("ucpu_core: register selects are two bits");
   end

   ucpu_op_e          op;
   logic              sub;
   logic [1:0]        dst_sel;
   logic [1:0]        src_sel;
   logic              rf_we;
   logic              use_load;
   logic [DATA_W-1:0] rd_a;
   logic [DATA_W-1:0] rd_b;
   logic [DATA_W-1:0] alu_y;
   logic [DATA_W-1:0] wr_data;

   ucpu_ctrl #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .mem_rdata (mem_rdata),
      .cond_in   (cond_in),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .op        (op),
      .sub       (sub),
      .dst_sel   (dst_sel),
      .src_sel   (src_sel),
      .rf_we     (rf_we),
      .use_load  (use_load)
   );

   ucpu_regfile #(
      .DATA_W (DATA_W),
      .NREGS  (NREGS)
   ) u_rf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (rf_we),
      .wr_sel   (dst_sel),
      .wr_data  (wr_data),
      .rd_a_sel (dst_sel),
      .rd_b_sel (src_sel),
      .rd_a     (rd_a),
      .rd_b     (rd_b)
   );

   ucpu_alu #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .op  (op),
      .sub (sub),
      .a   (rd_a),
      .b   (rd_b),
      .y   (alu_y)
   );

   assign wr_data   = use_load ? mem_rdata : alu_y;
   assign mem_wdata = rd_b;

   // R7: a store never coincides with a register write
   a_r7_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> !rf_we);

endmodule

// File: tb/tb_ucpu_core.sv
module tb_ucpu_core;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic       clk;
   logic       rst;
   logic [7:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_we;
   logic [7:0] mem_rdata;
   logic       cond_in;

   logic [7:0] mem [256];

   int n_checks;
   int n_fail;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   ucpu_core dut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata),
      .cond_in   (cond_in)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   function automatic logic [7:0] enc(input int op, input int b, input int a1, input int a2);
      return {2'(op), 1'(b), 2'(a1), 2'(a2), 1'b0};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic expect_store(input logic [7:0] a, input logic [7:0] d, input string tag);
      exp_q.push_back({a, d});
      tag_q.push_back(tag);
   endtask

   // monitor: every store is compared with the next expected item
   always @(negedge clk) begin
      if (!rst && mem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8/R9 unexpected store", int'({mem_addr, mem_wdata}), 0);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({mem_addr, mem_wdata} == e, t, int'({mem_addr, mem_wdata}), int'(e));
         end
         if (mem_addr == 8'hF8) cond_in = 1'b1;
      end
   end

   initial begin
      bit done;
      n_checks = 0;
      n_fail   = 0;
      cond_in  = 1'b0;
      rst      = 1'b1;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[8'hE0] = 8'h35;
      mem[8'hE1] = 8'h0C;
      mem[0]  = enc(0,1,0,0); mem[1]  = 8'hF0;   // store R0 (R1 reset value)
      mem[2]  = enc(0,1,0,3); mem[3]  = 8'hF1;   // store R3
      mem[4]  = enc(0,0,1,0); mem[5]  = 8'hE0;   // R1 <- M(E0)
      mem[6]  = enc(0,0,2,0); mem[7]  = 8'hE1;   // R2 <- M(E1)
      mem[8]  = enc(1,0,3,1);                    // R3 <- R1
      mem[9]  = enc(2,0,3,2) | 8'h01;            // R3 += R2, spare bit set
      mem[10] = enc(0,1,0,3); mem[11] = 8'hF2;
      mem[12] = enc(2,1,1,2);                    // R1 -= R2
      mem[13] = enc(0,1,0,1); mem[14] = 8'hF3;
      mem[15] = enc(1,1,0,2);                    // R0 <- ~R2
      mem[16] = enc(0,1,0,0); mem[17] = 8'hF4;
      mem[18] = enc(2,0,0,1);                    // R0 += R1 (wraps)
      mem[19] = enc(0,1,0,0); mem[20] = 8'hF5;
      mem[21] = enc(2,1,2,1);                    // R2 -= R1 (wraps)
      mem[22] = enc(0,1,0,2); mem[23] = 8'hF6;
      mem[24] = enc(3,0,0,0); mem[25] = 8'h40;   // jump
      mem[26] = enc(0,1,0,0); mem[27] = 8'hF7;   // must be skipped
      mem[8'h40] = enc(3,1,0,0); mem[8'h41] = 8'h50; // cond 0: not taken
      mem[8'h42] = enc(0,1,0,2); mem[8'h43] = 8'hF8;
      mem[8'h44] = enc(3,1,0,0); mem[8'h45] = 8'h60; // cond 1: taken
      mem[8'h46] = enc(0,1,0,0); mem[8'h47] = 8'hF9; // must be skipped
      mem[8'h50] = enc(0,1,0,0); mem[8'h51] = 8'hFB; // wrong-branch trap
      mem[8'h60] = enc(0,1,0,3); mem[8'h61] = 8'hFA;
      mem[8'h62] = enc(0,1,0,1); mem[8'h63] = 8'hFC;
      mem[8'h64] = enc(3,0,0,0); mem[8'h65] = 8'h64; // self loop

      expect_store(8'hF0, 8'h00, "R1 reset R0");
      expect_store(8'hF1, 8'h00, "R1 reset R3 / R4 store");
      expect_store(8'hF2, 8'h41, "R5 copy + R6 add R3=R3+R2 / R2 spare bit / R3 load");
      expect_store(8'hF3, 8'h29, "R6 sub");
      expect_store(8'hF4, 8'hF3, "R5 invert");
      expect_store(8'hF5, 8'h1C, "R6 add wrap");
      expect_store(8'hF6, 8'hE3, "R6 sub wrap");
      expect_store(8'hF8, 8'hE3, "R9 not taken, R8 jump target");
      expect_store(8'hFA, 8'h41, "R9 taken / R7 R3 untouched");
      expect_store(8'hFC, 8'h29, "R7 R1 untouched");

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
      rst = 1'b0;
      #1;
      check(mem_addr == 8'h00, "R1 first fetch address", int'(mem_addr), 0);

      done = 1'b0;
      for (int c = 0; c < WATCHDOG && !done; c++) begin
         @(negedge clk);
         if (exp_q.size() == 0) done = 1'b1;
      end
      if (!done) check(1'b0, "R10 watchdog expired", exp_q.size(), 0);

      repeat (10) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check(mem_addr == 8'h64 || mem_addr == 8'h65, "R8 self loop address",
               int'(mem_addr), 8'h64);
      end
      check(mem[8'hF7] == 8'h00, "R8 skipped store", int'(mem[8'hF7]), 0);
      check(mem[8'hF9] == 8'h00, "R9 skipped store", int'(mem[8'hF9]), 0);
      check(mem[8'hF2] == 8'h41, "R4 memory content", int'(mem[8'hF2]), 8'h41);
      check(mem[8'hE0] == 8'h35, "R10 load leaves memory", int'(mem[8'hE0]), 8'h35);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule